// File: doc/BRIEF.md
# Serial Frame Receiver with Multiprocessor Address Filtering

This block is the receive half of an asynchronous serial port. It oversamples the incoming line at sixteen baud ticks per bit and rebuilds each frame: 8-bit frames, or 9-bit frames with an extra bit after the data. It then decides whether the finished frame should be handed to software. When a frame is accepted, the block latches the byte and the extra bit into a holding buffer and raises a receive flag. That flag stays up until software clears it.

With the multiprocessor enable set, the block acts as a slave on a shared line. It examines frames tagged as addresses and raises the flag only when the byte matches this node. A node matches through its own masked address or through a broadcast pattern derived from the same two registers. In 9-bit operation, the extra bit marks a frame as an address (1) or as data (0). In 8-bit operation, the stop bit is used as that marker. The shift-register mode code turns the receiver off altogether, because that mode is served by other logic.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is a low start bit, then eight data bits with the least significant bit first, then (for mode codes 2'b10 and 2'b11 only) a ninth bit, then a stop bit. An accepted frame presents its byte on `rx_data`. Its ninth bit appears on `rx_bit9` in 9-bit modes; in 8-bit mode (code 2'b01), `rx_bit9` shows the received stop bit.
- R2: A start is taken from a low line seen in idle. It is confirmed by a two-of-three vote of the samples at ticks 7, 8 and 9 of the bit. A pulse that fails the vote returns the receiver to idle, and no frame is produced.
- R3: With `mp_en` low, every frame whose stop bit is high raises `rx_flag`, whatever its content.
- R4: Every completed frame sets `frame_err` to the inverse of its stop bit. A frame with a low stop bit never raises `rx_flag`.
- R5: Once set, `rx_flag` stays high until a cycle with `flag_clr` high. It reads low on the cycle after that clear.
- R6: A frame that completes while `rx_flag` is high is dropped. `rx_data` and `rx_bit9` keep their values.
- R7: In a 9-bit mode with `mp_en` high, a frame whose ninth bit is 0 never raises `rx_flag`.
- R8: With `mp_en` high, an address frame is accepted when every bit where `dev_mask` is 1 equals the same bit of `dev_addr`. Mask bits at 0 are don't-cares.
- R9: With `mp_en` high, an address frame is also accepted when the byte holds a 1 in every position where `dev_addr | dev_mask` is 1. This is the broadcast match.
- R10: In 8-bit mode with `mp_en` high, the flag rises only when the address matches (R8 or R9) and the stop bit is high.
- R11: Mode code 2'b00 disables reception. No frame raises `rx_flag` or changes `frame_err`, whatever the value of `mp_en`.
- R12: After reset, `rx_flag`, `frame_err`, `rx_data` and `rx_bit9` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_in | input | 1 | Serial receive line, idle high |
| frame_mode | input | 2 | 00 off, 01 8-bit frames, 10/11 9-bit frames |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| dev_addr | input | 8 | Node address |
| dev_mask | input | 8 | Significance mask for `dev_addr` (1 = compared) |
| flag_clr | input | 1 | Software clear of the receive flag |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit (or stop bit in 8-bit mode) of the last accepted frame |
| rx_flag | output | 1 | Receive flag |
| frame_err | output | 1 | Stop bit of the last completed frame was low |

## Verification
Some properties are checked on every cycle, whatever traffic is present. These are: the flag persists until cleared and falls after a clear; the buffer holds while the flag is up; the flag stays quiet in the disabled mode; and each rising flag agrees with the rules. Under filtering, the latched byte must pass the masked or the broadcast match. In 9-bit filtering the latched ninth bit must be 1, and in 8-bit mode it must show a valid stop, with `frame_err` clear. Other behaviour can only be shown by the bench driving real line waveforms. That covers bit order and the mid-bit vote, rejection of a glitch start, rejection of a non-matching address, and a second frame being dropped. It also covers frame errors from a low stop, and recovery after one.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;

    parameter int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_SHIFT  = 2'b00,
        MODE_8BIT   = 2'b01,
        MODE_9BIT_A = 2'b10,
        MODE_9BIT_B = 2'b11
    } rx_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              bit9;
        logic              stop;
    } rx_frame_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic nine_bit(input rx_mode_e m);
        return (m == MODE_9BIT_A) || (m == MODE_9BIT_B);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= 1'b1;
                else     stg[g] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= 1'b1;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import mpu_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      baud_tick,
    input  logic      rx_s,
    input  logic      enable,
    input  logic      use_ninth,
    output logic      frame_done,
    output rx_frame_t frame
);
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned IW = $clog2(BYTE_W);
    localparam logic [CW-1:0] T_S0  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] T_S1  = CW'(OSR / 2);
    localparam logic [CW-1:0] T_S2  = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] T_END = CW'(OSR - 1);
    localparam logic [IW-1:0] LAST  = IW'(BYTE_W - 1);

    rx_state_e         state;
    logic [CW-1:0]     tick_cnt;
    logic [IW-1:0]     bit_idx;
    logic [1:0]        early;
    logic [BYTE_W-1:0] shadow_data;
    logic              shadow_b9;
    logic              vote;

    assign vote = vote3(early[0], early[1], rx_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            tick_cnt    <= '0;
            bit_idx     <= '0;
            early       <= '0;
            shadow_data <= '0;
            shadow_b9   <= 1'b0;
            frame       <= '0;
            frame_done  <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (!enable) begin
                state    <= ST_IDLE;
                tick_cnt <= '0;
            end else if (baud_tick) begin
                if (state == ST_IDLE) begin
                    if (!rx_s) begin
                        state    <= ST_START;
                        tick_cnt <= '0;
                    end
                end else begin
                    tick_cnt <= (tick_cnt == T_END) ? '0 : tick_cnt + 1'b1;
                    if (tick_cnt == T_S0) early[0] <= rx_s;
                    if (tick_cnt == T_S1) early[1] <= rx_s;
                    if (tick_cnt == T_S2) begin
                        case (state)
                            ST_START: if (vote) state <= ST_IDLE;
                            ST_DATA:  shadow_data[bit_idx] <= vote;
                            ST_NINTH: shadow_b9 <= vote;
                            ST_STOP: begin
                                frame      <= '{data: shadow_data, bit9: shadow_b9, stop: vote};
                                frame_done <= 1'b1;
                                state      <= ST_IDLE;
                            end
                            default:  state <= ST_IDLE;
                        endcase
                    end
                    if (tick_cnt == T_END) begin
                        case (state)
                            ST_START: begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                            end
                            ST_DATA: begin
                                if (bit_idx == LAST) state <= use_ninth ? ST_NINTH : ST_STOP;
                                else                 bit_idx <= bit_idx + 1'b1;
                            end
                            ST_NINTH: state <= ST_STOP;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match
    import mpu_rx_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] mask,
    output logic              hit
);
    logic [BYTE_W-1:0] own_ok;
    logic [BYTE_W-1:0] bc_ok;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign own_ok[i] = ~mask[i] | ~(data[i] ^ addr[i]);
        assign bc_ok[i]  = ~(addr[i] | mask[i]) | data[i];
    end

    assign hit = (&own_ok) | (&bc_ok);
endmodule

// File: rtl/rx_accept_ctrl.sv
module rx_accept_ctrl
    import mpu_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  rx_frame_t         frame,
    input  rx_mode_e          mode,
    input  logic              mp_en,
    input  logic              addr_hit,
    input  logic              flag_clr,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_flag,
    output logic              frame_err
);
    logic active;
    logic wanted;
    logic load;

    always_comb begin
        active = (mode != MODE_SHIFT);
        if (!mp_en)              wanted = 1'b1;
        else if (nine_bit(mode)) wanted = frame.bit9 & addr_hit;
        else                     wanted = addr_hit;
        load = frame_done & active & frame.stop & wanted & ~rx_flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_flag   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_flag <= (rx_flag & ~flag_clr) | load;
            if (load) begin
                rx_data <= frame.data;
                rx_bit9 <= nine_bit(mode) ? frame.bit9 : frame.stop;
            end
            if (frame_done && active) frame_err <= ~frame.stop;
        end
    end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mpu_rx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rx_in,
    input  logic [1:0]        frame_mode,
    input  logic              mp_en,
    input  logic [BYTE_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] dev_mask,
    input  logic              flag_clr,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_flag,
    output logic              frame_err
);
    rx_mode_e  mode;
    logic      rx_s;
    logic      frame_done;
    rx_frame_t frame;
    logic      addr_hit;

    assign mode = rx_mode_e'(frame_mode);

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (rx_s)
    );

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .rx_s       (rx_s),
        .enable     (mode != MODE_SHIFT),
        .use_ninth  (nine_bit(mode)),
        .frame_done (frame_done),
        .frame      (frame)
    );

    rx_addr_match u_match (
        .data (frame.data),
        .addr (dev_addr),
        .mask (dev_mask),
        .hit  (addr_hit)
    );

    rx_accept_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .frame      (frame),
        .mode       (mode),
        .mp_en      (mp_en),
        .addr_hit   (addr_hit),
        .flag_clr   (flag_clr),
        .rx_data    (rx_data),
        .rx_bit9    (rx_bit9),
        .rx_flag    (rx_flag),
        .frame_err  (frame_err)
    );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] frame_mode,
    input logic       mp_en,
    input logic [7:0] dev_addr,
    input logic [7:0] dev_mask,
    input logic       flag_clr,
    input logic [7:0] rx_data,
    input logic       rx_bit9,
    input logic       rx_flag,
    input logic       frame_err
);
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
        rx_flag && !flag_clr |=> rx_flag);

    p_flag_clear_r5: assert property (@(posedge clk) disable iff (rst)
        rx_flag && flag_clr |=> !rx_flag);

    p_buffer_keep_r6: assert property (@(posedge clk) disable iff (rst)
        rx_flag |=> $stable(rx_data) && $stable(rx_bit9));

    p_off_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (frame_mode == 2'b00) && !rx_flag |=> !rx_flag);

    p_addr_match_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flag) && $past(mp_en) |->
            ((((rx_data ^ $past(dev_addr)) & $past(dev_mask)) == 8'h00) ||
             ((rx_data | ~($past(dev_addr) | $past(dev_mask))) == 8'hFF)));

    p_ninth_set_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flag) && $past(mp_en) && $past(frame_mode[1]) |-> rx_bit9);

    p_stop_valid_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flag) && ($past(frame_mode) == 2'b01) |-> rx_bit9);

    p_no_err_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flag) |-> !frame_err);
endmodule

bind mp_uart_rx mp_uart_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_mode (frame_mode),
    .mp_en      (mp_en),
    .dev_addr   (dev_addr),
    .dev_mask   (dev_mask),
    .flag_clr   (flag_clr),
    .rx_data    (rx_data),
    .rx_bit9    (rx_bit9),
    .rx_flag    (rx_flag),
    .frame_err  (frame_err)
);

// File: tb/mp_uart_rx_tb.sv
module mp_uart_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 64;      // 16 ticks of 4 clocks
    localparam int WD_LIMIT   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b1;
    logic [1:0] frame_mode = 2'b01;
    logic       mp_en = 1'b0;
    logic [7:0] dev_addr = 8'h00;
    logic [7:0] dev_mask = 8'h00;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_flag, frame_err;
    logic [1:0] div;
    logic       baud_tick;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    logic       e_flag = 0, e_b9 = 0, e_err = 0;
    logic [7:0] e_data = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) div <= '0;
        else     div <= div + 2'd1;
    end
    assign baud_tick = (div == 2'd3);

    mp_uart_rx u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_in(rx_in),
        .frame_mode(frame_mode), .mp_en(mp_en), .dev_addr(dev_addr),
        .dev_mask(dev_mask), .flag_clr(flag_clr), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_flag(rx_flag), .frame_err(frame_err)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "rx_flag", int'(rx_flag), int'(e_flag));
        check(tag, "frame_err", int'(frame_err), int'(e_err));
        check(tag, "rx_data", int'(rx_data), int'(e_data));
        check(tag, "rx_bit9", int'(rx_bit9), int'(e_b9));
    endtask

    function automatic bit own_match(input logic [7:0] d, input logic [7:0] a, input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i] && (d[i] != a[i])) return 0;
        return 1;
    endfunction

    function automatic bit bc_match(input logic [7:0] d, input logic [7:0] a, input logic [7:0] m);
        for (int i = 0; i < 8; i++) if ((a[i] || m[i]) && !d[i]) return 0;
        return 1;
    endfunction

    function automatic bit expect_accept(input logic [1:0] mode, input logic mp, input logic [7:0] a,
                                         input logic [7:0] m, input logic [7:0] d, input logic b9,
                                         input logic stp);
        bit hit;
        if (mode == 2'b00 || !stp) return 0;
        if (!mp) return 1;
        hit = own_match(d, a, m) || bc_match(d, a, m);
        if (mode == 2'b01) return hit;
        return b9 && hit;
    endfunction

    task automatic drive_bit(input logic v);
        rx_in = v;
        repeat (BIT_CLKS) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [1:0] mode, input logic [7:0] d, input logic b9, input logic stp);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (mode[1]) drive_bit(b9);
        drive_bit(stp);
        rx_in = 1'b1;
        repeat (2 * BIT_CLKS) @(posedge clk);
        #1;
    endtask

    task automatic do_frame(input logic [1:0] mode, input logic mp, input logic [7:0] a, input logic [7:0] m,
                            input logic [7:0] d, input logic b9, input logic stp, input string tag);
        frame_mode = mode; mp_en = mp; dev_addr = a; dev_mask = m;
        if (expect_accept(mode, mp, a, m, d, b9, stp) && !e_flag) begin
            e_flag = 1; e_data = d; e_b9 = mode[1] ? b9 : stp;
        end
        if (mode != 2'b00) e_err = ~stp;
        send_frame(mode, d, b9, stp);
        check_all(tag);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(posedge clk); #1;
        flag_clr = 1'b0;
        e_flag = 0;
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check_all("R12 reset");

        // R1/R3: plain 8-bit frame, stop shown as ninth bit
        do_frame(2'b01, 0, 8'h00, 8'h00, 8'hA5, 1'b0, 1'b1, "R1 R3 8bit");
        // R6: second frame dropped while flag is up
        do_frame(2'b01, 0, 8'h00, 8'h00, 8'h3C, 1'b0, 1'b1, "R6 drop");
        repeat (100) @(posedge clk); #1;
        check("R5 hold", "rx_flag", int'(rx_flag), 1);
        clear_flag();
        check("R5 clear", "rx_flag", int'(rx_flag), 0);
        // R1: 9-bit frame with ninth bit 0
        do_frame(2'b10, 0, 8'h00, 8'h00, 8'h81, 1'b0, 1'b1, "R1 9bit");
        clear_flag();
        // R4: low stop bit
        do_frame(2'b01, 0, 8'h00, 8'h00, 8'h5E, 1'b0, 1'b0, "R4 bad stop");
        // R2: glitch start of three ticks
        rx_in = 1'b0;
        repeat (12) @(posedge clk); #1;
        rx_in = 1'b1;
        repeat (3 * BIT_CLKS) @(posedge clk); #1;
        check_all("R2 false start");
        do_frame(2'b11, 0, 8'h00, 8'h00, 8'h4B, 1'b1, 1'b1, "R2 after glitch");
        clear_flag();
        // R8/R7/R9: 9-bit filtering, addr 0x56 mask 0xFC
        do_frame(2'b11, 1, 8'h56, 8'hFC, 8'h57, 1'b1, 1'b1, "R8 match");
        clear_flag();
        do_frame(2'b11, 1, 8'h56, 8'hFC, 8'h5A, 1'b1, 1'b1, "R8 mismatch");
        do_frame(2'b11, 1, 8'h56, 8'hFC, 8'h57, 1'b0, 1'b1, "R7 data frame");
        do_frame(2'b10, 1, 8'h56, 8'hFC, 8'hFF, 1'b1, 1'b1, "R9 broadcast");
        clear_flag();
        do_frame(2'b10, 1, 8'h56, 8'hFC, 8'hFD, 1'b1, 1'b1, "R9 near broadcast");
        // R10: 8-bit filtering with stop as marker
        do_frame(2'b01, 1, 8'h56, 8'hFC, 8'h55, 1'b0, 1'b1, "R10 match");
        clear_flag();
        do_frame(2'b01, 1, 8'h56, 8'hFC, 8'h5A, 1'b0, 1'b1, "R10 mismatch");
        do_frame(2'b01, 1, 8'h56, 8'hFC, 8'h57, 1'b0, 1'b0, "R10 bad stop");
        // R11: disabled mode
        do_frame(2'b00, 1, 8'h56, 8'hFC, 8'h57, 1'b1, 1'b1, "R11 off mp");
        do_frame(2'b00, 0, 8'h00, 8'h00, 8'h12, 1'b1, 1'b1, "R11 off");

        // Random traffic across R1 R3 R4 R6 R7 R8 R9 R10
        for (int n = 0; n < 50; n++) begin
            logic [1:0] md;
            logic       mp, b9, stp;
            logic [7:0] a, m, d;
            md  = 2'(1 + ($urandom % 3));
            mp  = 1'($urandom % 2);
            a   = 8'($urandom);
            m   = 8'($urandom) | (($urandom % 2) ? 8'hF0 : 8'h00);
            d   = ($urandom % 2) ? (a ^ (8'($urandom) & ~m)) : 8'($urandom);
            b9  = 1'($urandom % 2);
            stp = (($urandom % 8) != 0);
            if (($urandom % 10) < 7) clear_flag();
            do_frame(md, mp, a, m, d, b9, stp, "R8 random");
        end
        summary();
    end
endmodule